// File: doc/BRIEF.md
# Programmable Pad Cell Bank

A bank of programmable pad cells. Each cell owns one pad and is shaped by a static configuration word. The core always sees two versions of the pad: the raw pad level and a copy captured on the clock edge. The drive value and the drive enable each take one of two routes to the pad, chosen per cell: straight from the core, or through a capture register.

The drive enable comes either from the cell's own core enable or from one of a few enables shared across the bank. The output stage can drive true data, inverted data, or act as an inverting open-drain pull-down. The pad is modelled as three lines: a pad-input line, a drive value and a drive enable.

Top module: `padbank_top`

## Requirements
- R1: An edge with `syncClr` high clears the input, data and enable capture registers of every cell to 0, whatever the clock enables are.
- R2: `coreInComb[i]` always equals `padIn[i]`, with no clock edge in between.
- R3: With the input-register select (config bit 5) at 1, an edge with `inCe[i]` high loads `padIn[i]`. The value shows on `coreInReg[i]` after that edge, and the register holds while `inCe[i]` is low. With the select at 0, `coreInReg[i]` reads 0.
- R4: Data-register select (bit 4) at 0 takes the drive data straight from `coreData[i]`. At 1 it takes the data register, which loads `coreData[i]` on edges with `outCe[i]` high, so there is one cycle of latency.
- R5: Enable-register select (bit 3) at 0 takes the enable straight from its source. At 1 it takes the enable register, which loads the source on edges with `oeCe[i]` high.
- R6: Enable source (bit 2) at 0 is `coreOe[i]`. At 1 the source is `globalOe[k]`, where k is bits 1:0. An index k of `NUM_GLOBAL_OE` or more gives an enable of 0.
- R7: Direction (bits 9:8): 2'b00 (input only) and 2'b11 (reserved) never drive the pad. 2'b01 (output) and 2'b10 (bidirectional) drive whenever the selected enable is 1 and the polarity permits.
- R8: Polarity (bits 7:6) 2'b00 drives `padOut` = data. Polarity 2'b01 drives `padOut` = NOT data. In both modes `padDrv` equals the selected enable.
- R9: Polarity 2'b10 is inverting open-drain: `padDrv` is 1 only when enable and data are both 1, and `padOut` is then 0. Polarity 2'b11 never drives.
- R10: Whenever `padDrv[i]` is 0, `padOut[i]` is 0.
- R11: Cell i's configuration word sits at bits `[i*10 +: 10]` of `cellCfg` and affects only cell i's pad and input lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all capture registers |
| syncClr | input | 1 | Synchronous clear of all capture registers, active high |
| cellCfg | input | NUM_CELLS*10 | Static configuration words, one per cell |
| coreData | input | NUM_CELLS | Core drive data per cell |
| coreOe | input | NUM_CELLS | Core drive enable per cell |
| globalOe | input | NUM_GLOBAL_OE | Bank-wide shared drive enables |
| inCe | input | NUM_CELLS | Clock enable of the input capture registers |
| outCe | input | NUM_CELLS | Clock enable of the data capture registers |
| oeCe | input | NUM_CELLS | Clock enable of the enable capture registers |
| padIn | input | NUM_CELLS | Level seen at each pad |
| padOut | output | NUM_CELLS | Value driven onto each pad |
| padDrv | output | NUM_CELLS | Drive enable of each pad; 0 releases the pad |
| coreInComb | output | NUM_CELLS | Raw pad level returned to the core |
| coreInReg | output | NUM_CELLS | Captured pad level returned to the core |

## Verification
The main sweep gives the four cells different configuration words and steps through all 1024 values of the word. Random data, enables, clock enables and occasional clears are applied every cycle. This separates errors in the route selection (direct versus registered) from errors in the enable source and in the polarity decode.

Directed steps hold a registered path's input steady across one edge and then drop its clock enable. This tells a one-cycle latency apart from a direct path, and holding from reloading. Further directed patterns aim the global index past the last shared enable. They also set neighbouring cells to differing directions, which catches index and cross-cell slips that the random sweep might hide.

// File: rtl/padbank_pkg.sv
package padbank_pkg;

  // Width of the shared-enable index inside a configuration word.
  localparam int GIDX_W = 2;

  typedef enum logic [1:0] {
    DIR_IN    = 2'b00,
    DIR_OUT   = 2'b01,
    DIR_BIDIR = 2'b10,
    DIR_RSVD  = 2'b11
  } padDir_e;

  typedef enum logic [1:0] {
    POL_HIGH  = 2'b00,
    POL_LOW   = 2'b01,
    POL_ODINV = 2'b10,
    POL_RSVD  = 2'b11
  } padPol_e;

  // Per-cell configuration word, MSB first: [9:8] dir, [7:6] pol,
  // [5] inReg, [4] outReg, [3] oeReg, [2] oeGlobal, [1:0] gIdx.
  typedef struct packed {
    padDir_e           dir;
    padPol_e           pol;
    logic              inReg;
    logic              outReg;
    logic              oeReg;
    logic              oeGlobal;
    logic [GIDX_W-1:0] gIdx;
  } cellCfg_t;

  localparam int CFG_W = $bits(cellCfg_t);

  // Strobes from the control decode to the per-cell datapath.
  typedef struct packed {
    logic inLoad;
    logic inShow;
    logic outLoad;
    logic outPickReg;
    logic oeLoad;
    logic oePickReg;
    logic oeRaw;
    logic driveOk;
    logic invData;
    logic openDrain;
  } cellStrobe_t;

endpackage

// File: rtl/padbank_ctrl.sv
module padbank_ctrl
  import padbank_pkg::*;
#(
  parameter int NUM_CELLS     = 4,
  parameter int NUM_GLOBAL_OE = 3
) (
  input  logic [NUM_CELLS*CFG_W-1:0]  cfgVec,
  input  logic [NUM_CELLS-1:0]        coreOe,
  input  logic [NUM_GLOBAL_OE-1:0]    globalOe,
  input  logic [NUM_CELLS-1:0]        inCe,
  input  logic [NUM_CELLS-1:0]        outCe,
  input  logic [NUM_CELLS-1:0]        oeCe,
  output cellStrobe_t [NUM_CELLS-1:0] strobe
);

  localparam int GSLOTS = 1 << GIDX_W;
  localparam int GUSED  = (NUM_GLOBAL_OE < GSLOTS) ? NUM_GLOBAL_OE : GSLOTS;

  // Shared enables widened to every index value; missing slots read 0.
  logic [GSLOTS-1:0] gPad;

  always_comb begin
    gPad = '0;
    for (int k = 0; k < GUSED; k++) begin
      gPad[k] = globalOe[k];
    end
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    cellCfg_t    cfg;
    cellStrobe_t s;

    assign cfg = cellCfg_t'(cfgVec[c*CFG_W +: CFG_W]);

    always_comb begin
      s            = '0;
      s.inLoad     = cfg.inReg & inCe[c];
      s.inShow     = cfg.inReg;
      s.outLoad    = outCe[c];
      s.outPickReg = cfg.outReg;
      s.oeLoad     = oeCe[c];
      s.oePickReg  = cfg.oeReg;
      s.oeRaw      = cfg.oeGlobal ? gPad[cfg.gIdx] : coreOe[c];
      s.driveOk    = ((cfg.dir == DIR_OUT) || (cfg.dir == DIR_BIDIR))
                     && (cfg.pol != POL_RSVD);
      s.invData    = (cfg.pol == POL_LOW);
      s.openDrain  = (cfg.pol == POL_ODINV);
    end

    assign strobe[c] = s;
  end

endmodule

// File: rtl/padbank_dp.sv
module padbank_dp
  import padbank_pkg::*;
#(
  parameter int NUM_CELLS = 4
) (
  input  logic                        clk,
  input  logic                        syncClr,
  input  cellStrobe_t [NUM_CELLS-1:0] strobe,
  input  logic [NUM_CELLS-1:0]        coreData,
  input  logic [NUM_CELLS-1:0]        padIn,
  output logic [NUM_CELLS-1:0]        padOut,
  output logic [NUM_CELLS-1:0]        padDrv,
  output logic [NUM_CELLS-1:0]        coreInComb,
  output logic [NUM_CELLS-1:0]        coreInReg
);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    cellStrobe_t s;
    logic inQ, outQ, oeQ;
    logic dataSel, enSel;
    logic drvBit, outBit;

    assign s = strobe[c];

    // Input capture register.
    always_ff @(posedge clk) begin
      if (syncClr)       inQ <= 1'b0;
      else if (s.inLoad) inQ <= padIn[c];
    end

    // Drive data capture register.
    always_ff @(posedge clk) begin
      if (syncClr)        outQ <= 1'b0;
      else if (s.outLoad) outQ <= coreData[c];
    end

    // Drive enable capture register.
    always_ff @(posedge clk) begin
      if (syncClr)       oeQ <= 1'b0;
      else if (s.oeLoad) oeQ <= s.oeRaw;
    end

    assign dataSel = s.outPickReg ? outQ : coreData[c];
    assign enSel   = s.oePickReg  ? oeQ  : s.oeRaw;

    always_comb begin
      drvBit = 1'b0;
      outBit = 1'b0;
      if (s.driveOk) begin
        if (s.openDrain) begin
          drvBit = enSel & dataSel;
        end else begin
          drvBit = enSel;
          outBit = enSel & (dataSel ^ s.invData);
        end
      end
    end

    assign padDrv[c]     = drvBit;
    assign padOut[c]     = outBit;
    assign coreInComb[c] = padIn[c];
    assign coreInReg[c]  = s.inShow & inQ;
  end

endmodule

// File: rtl/padbank_top.sv
module padbank_top
  import padbank_pkg::*;
#(
  parameter int NUM_CELLS     = 4,
  parameter int NUM_GLOBAL_OE = 3
) (
  input  logic                       clk,
  input  logic                       syncClr,
  input  logic [NUM_CELLS*CFG_W-1:0] cellCfg,
  input  logic [NUM_CELLS-1:0]       coreData,
  input  logic [NUM_CELLS-1:0]       coreOe,
  input  logic [NUM_GLOBAL_OE-1:0]   globalOe,
  input  logic [NUM_CELLS-1:0]       inCe,
  input  logic [NUM_CELLS-1:0]       outCe,
  input  logic [NUM_CELLS-1:0]       oeCe,
  input  logic [NUM_CELLS-1:0]       padIn,
  output logic [NUM_CELLS-1:0]       padOut,
  output logic [NUM_CELLS-1:0]       padDrv,
  output logic [NUM_CELLS-1:0]       coreInComb,
  output logic [NUM_CELLS-1:0]       coreInReg
);

  cellStrobe_t [NUM_CELLS-1:0] strobe;

  padbank_ctrl #(
    .NUM_CELLS    (NUM_CELLS),
    .NUM_GLOBAL_OE(NUM_GLOBAL_OE)
  ) ctrl_i (
    .cfgVec  (cellCfg),
    .coreOe  (coreOe),
    .globalOe(globalOe),
    .inCe    (inCe),
    .outCe   (outCe),
    .oeCe    (oeCe),
    .strobe  (strobe)
  );

  padbank_dp #(
    .NUM_CELLS(NUM_CELLS)
  ) dp_i (
    .clk       (clk),
    .syncClr   (syncClr),
    .strobe    (strobe),
    .coreData  (coreData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padDrv    (padDrv),
    .coreInComb(coreInComb),
    .coreInReg (coreInReg)
  );

endmodule

// File: rtl/padbank_chk.sv
module padbank_chk
  import padbank_pkg::*;
#(
  parameter int NUM_CELLS     = 4,
  parameter int NUM_GLOBAL_OE = 3
) (
  input logic                       clk,
  input logic                       syncClr,
  input logic [NUM_CELLS*CFG_W-1:0] cellCfg,
  input logic [NUM_CELLS-1:0]       coreData,
  input logic [NUM_CELLS-1:0]       inCe,
  input logic [NUM_CELLS-1:0]       outCe,
  input logic [NUM_CELLS-1:0]       padIn,
  input logic [NUM_CELLS-1:0]       padOut,
  input logic [NUM_CELLS-1:0]       padDrv,
  input logic [NUM_CELLS-1:0]       coreInReg
);

  // R1: the edge that ends a clear leaves every captured input at 0.
  a_r1_clear_in: assert property (@(posedge clk)
    $fell(syncClr) |-> (coreInReg == '0));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    cellCfg_t cfg;
    assign cfg = cellCfg_t'(cellCfg[c*CFG_W +: CFG_W]);

    a_r3_in_latency: assert property (@(posedge clk) disable iff (syncClr)
      (cfg.inReg && inCe[c]) |=> (!cfg.inReg || coreInReg[c] == $past(padIn[c])));

    a_r3_in_hidden: assert property (@(posedge clk) disable iff (syncClr)
      !cfg.inReg |-> !coreInReg[c]);

    a_r4_out_latency: assert property (@(posedge clk) disable iff (syncClr)
      outCe[c] |=> (!(cfg.outReg && cfg.pol == POL_HIGH && padDrv[c])
                    || padOut[c] == $past(coreData[c])));

    a_r6_void_global: assert property (@(posedge clk) disable iff (syncClr)
      (cfg.oeGlobal && !cfg.oeReg && int'(cfg.gIdx) >= NUM_GLOBAL_OE) |-> !padDrv[c]);

    a_r7_input_quiet: assert property (@(posedge clk) disable iff (syncClr)
      (cfg.dir == DIR_IN || cfg.dir == DIR_RSVD) |-> !padDrv[c]);

    a_r9_odrain_low: assert property (@(posedge clk) disable iff (syncClr)
      (cfg.pol == POL_ODINV && padDrv[c]) |-> !padOut[c]);

    a_r10_released_low: assert property (@(posedge clk) disable iff (syncClr)
      !padDrv[c] |-> !padOut[c]);
  end

endmodule

bind padbank_top padbank_chk #(
  .NUM_CELLS    (NUM_CELLS),
  .NUM_GLOBAL_OE(NUM_GLOBAL_OE)
) chk_i (
  .clk      (clk),
  .syncClr  (syncClr),
  .cellCfg  (cellCfg),
  .coreData (coreData),
  .inCe     (inCe),
  .outCe    (outCe),
  .padIn    (padIn),
  .padOut   (padOut),
  .padDrv   (padDrv),
  .coreInReg(coreInReg)
);

// File: tb/padbank_top_tb.sv
module padbank_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC   = 4;
  localparam int NG   = 3;
  localparam int CFGW = 10;

  logic            clk = 1'b0;
  logic            syncClr = 1'b1;
  logic [NC*CFGW-1:0] cellCfg = '0;
  logic [NC-1:0]   coreData = '0, coreOe = '0, inCe = '0, outCe = '0, oeCe = '0, padIn = '0;
  logic [NG-1:0]   globalOe = '0;
  logic [NC-1:0]   padOut, padDrv, coreInComb, coreInReg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state.
  bit mIn[NC];
  bit mOut[NC];
  bit mOe[NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  padbank_top #(.NUM_CELLS(NC), .NUM_GLOBAL_OE(NG)) dut_i (
    .clk(clk), .syncClr(syncClr), .cellCfg(cellCfg), .coreData(coreData),
    .coreOe(coreOe), .globalOe(globalOe), .inCe(inCe), .outCe(outCe),
    .oeCe(oeCe), .padIn(padIn), .padOut(padOut), .padDrv(padDrv),
    .coreInComb(coreInComb), .coreInReg(coreInReg)
  );

  function automatic logic [CFGW-1:0] mk(int dir, int pol, int inS, int outS,
                                         int oeS, int glob, int idx);
    return {dir[1:0], pol[1:0], inS[0], outS[0], oeS[0], glob[0], idx[1:0]};
  endfunction

  function automatic logic [NC*CFGW-1:0] all(logic [CFGW-1:0] w);
    logic [NC*CFGW-1:0] v;
    for (int i = 0; i < NC; i++) v[i*CFGW +: CFGW] = w;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit srcEn(int i);
    logic [CFGW-1:0] w = cellCfg[i*CFGW +: CFGW];
    int idx = int'(w[1:0]);
    if (w[2]) return (idx < NG) ? globalOe[idx] : 1'b0;
    return coreOe[i];
  endfunction

  task automatic compareAll();
    for (int i = 0; i < NC; i++) begin
      logic [CFGW-1:0] w = cellCfg[i*CFGW +: CFGW];
      int dir = int'(w[9:8]);
      int pol = int'(w[7:6]);
      bit data = w[4] ? mOut[i] : coreData[i];
      bit en   = w[3] ? mOe[i]  : srcEn(i);
      bit may  = (dir == 1 || dir == 2);
      bit eDrv = 0, eOut = 0;
      bit eReg = w[5] ? mIn[i] : 1'b0;
      case (pol)
        0: begin eDrv = may && en; eOut = eDrv && data;  end
        1: begin eDrv = may && en; eOut = eDrv && !data; end
        2: begin eDrv = may && en && data; eOut = 0;     end
        default: begin eDrv = 0; eOut = 0; end
      endcase
      chk(coreInComb[i] == padIn[i], "R2 comb input", coreInComb[i], padIn[i]);
      chk(coreInReg[i] == eReg, "R3 captured input", coreInReg[i], eReg);
      chk(padDrv[i] == eDrv, "R7 drive enable", padDrv[i], eDrv);
      chk(padOut[i] == eOut, "R8 drive value", padOut[i], eOut);
      chk(padDrv[i] || !padOut[i], "R10 released low", padOut[i], 0);
    end
  endtask

  // One clock: the model follows the edge, outputs compared mid low phase.
  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin
      logic [CFGW-1:0] w = cellCfg[i*CFGW +: CFGW];
      if (syncClr) begin
        mIn[i] = 0; mOut[i] = 0; mOe[i] = 0;
      end else begin
        if (w[5] && inCe[i]) mIn[i] = padIn[i];
        if (outCe[i]) mOut[i] = coreData[i];
        if (oeCe[i])  mOe[i]  = srcEn(i);
      end
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin mIn[i] = 0; mOut[i] = 0; mOe[i] = 0; end
    @(negedge clk);
    // R1: clear wins over enabled loads.
    cellCfg = all(mk(1, 0, 1, 1, 1, 0, 0));
    padIn = '1; coreData = '1; coreOe = '1; inCe = '1; outCe = '1; oeCe = '1;
    tick(); tick();
    chk(coreInReg == '0, "R1 input reg cleared", coreInReg, 0);
    chk(padDrv == '0, "R1 enable reg cleared", padDrv, 0);
    chk(padOut == '0, "R1 data reg cleared", padOut, 0);
    syncClr = 0;
    #1 chk(padDrv == '0, "R5 enable not yet captured", padDrv, 0);
    tick();
    chk(coreInReg == '1, "R3 input one edge later", coreInReg, 15);
    chk(padDrv == '1, "R5 enable one edge later", padDrv, 15);
    chk(padOut == '1, "R4 data one edge later", padOut, 15);
    coreData = '0; outCe = '0; padIn = '0; inCe = '0;
    tick();
    chk(padOut == '1, "R4 data reg holds", padOut, 15);
    chk(coreInReg == '1, "R3 input reg holds", coreInReg, 15);
    cellCfg = all(mk(1, 0, 0, 0, 1, 0, 0));
    #1 chk(padOut == '0, "R4 direct data path", padOut, 0);
    chk(coreInReg == '0, "R3 hidden when unselected", coreInReg, 0);
    // R6: shared enable source.
    coreOe = '0; globalOe = 3'b010; coreData = '1;
    cellCfg = all(mk(2, 0, 0, 0, 0, 1, 1));
    #1 chk(padDrv == '1, "R6 shared index 1", padDrv, 15);
    cellCfg = all(mk(2, 0, 0, 0, 0, 1, 0));
    #1 chk(padDrv == '0, "R6 shared index 0", padDrv, 0);
    globalOe = '1;
    cellCfg = all(mk(2, 0, 0, 0, 0, 1, 3));
    #1 chk(padDrv == '0, "R6 index past last shared enable", padDrv, 0);
    // R7: direction codes.
    coreOe = '1;
    cellCfg = all(mk(0, 0, 0, 0, 0, 0, 0));
    #1 chk(padDrv == '0, "R7 input only", padDrv, 0);
    cellCfg = all(mk(3, 0, 0, 0, 0, 0, 0));
    #1 chk(padDrv == '0, "R7 reserved direction", padDrv, 0);
    cellCfg = all(mk(2, 0, 0, 0, 0, 0, 0));
    #1 chk(padDrv == '1, "R7 bidirectional drives", padDrv, 15);
    // R8: active low.
    cellCfg = all(mk(1, 1, 0, 0, 0, 0, 0));
    coreData = 4'b1010;
    #1 chk(padOut == 4'b0101, "R8 active low", padOut, 5);
    chk(padDrv == '1, "R8 active low enable", padDrv, 15);
    // R9: open drain and reserved polarity.
    cellCfg = all(mk(1, 2, 0, 0, 0, 0, 0));
    #1 chk(padDrv == 4'b1010, "R9 open drain pulls on data 1", padDrv, 10);
    chk(padOut == '0, "R9 open drain drives low", padOut, 0);
    cellCfg = all(mk(1, 3, 0, 0, 0, 0, 0));
    #1 chk(padDrv == '0, "R9 reserved polarity", padDrv, 0);
    // R11: per-cell independence.
    cellCfg = all(mk(0, 0, 0, 0, 0, 0, 0));
    cellCfg[0 +: CFGW] = mk(1, 0, 0, 0, 0, 0, 0);
    coreData = '1;
    #1 chk(padDrv == 4'b0001, "R11 only cell 0 drives", padDrv, 1);
    cellCfg[2*CFGW +: CFGW] = mk(1, 1, 0, 0, 0, 0, 0);
    #1 chk(padDrv == 4'b0101 && padOut == 4'b0001, "R11 cell 2 own polarity",
           {padDrv, padOut}, 8'h51);
    tick();
    // Sweep of every configuration word, different per cell.
    for (int c = 0; c < 1024; c++) begin
      for (int i = 0; i < NC; i++) cellCfg[i*CFGW +: CFGW] = 10'((c + i*37) % 1024);
      for (int k = 0; k < 4; k++) begin
        coreData = 4'($urandom); coreOe = 4'($urandom); padIn = 4'($urandom);
        globalOe = 3'($urandom);
        inCe  = 4'($urandom) | 4'($urandom);
        outCe = 4'($urandom) | 4'($urandom);
        oeCe  = 4'($urandom) | 4'($urandom);
        syncClr = (($urandom % 64) == 0);
        tick();
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule